// File: doc/BRIEF.md
# Interrupt Cause Register with Masking

This block gathers the one-cycle event pulses produced by the transmit, receive and link sections of a network controller. It stores each one in a sticky cause bit and presents the bits as a 32-bit register behind a simple read and write strobe interface. Software reads the register to learn which events happened. The read also clears every bit, so a read acknowledges all pending causes. Software can instead write ones to clear chosen bits.

A separately held enable mask is ANDed with the cause bits. The OR of the result drives a single level interrupt, which is registered. The link cause bit is set by an edge detector that fires on either edge of the link-up level. The transmit write-back cause can be deferred by a reloadable down-counter, so that a burst of write-backs raises one late cause instead of many early ones.

Top module: `irq_cause_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, every cause bit reads 0 and `irq_out` is 0.
- R2: An event pulse sampled at a clock edge sets its cause bit at that edge. The bit stays set until a read or a write-one clears it.
- R3: `reg_rdata` always shows the cause bits. A clock edge with `reg_rd` high clears every cause bit.
- R4: A clock edge with `reg_wr` high clears each cause bit whose `reg_wdata` bit is 1. Bits whose `reg_wdata` bit is 0 keep their value.
- R5: If an event arrives at the same edge as a read or a write-one that clears its bit, the bit is set after that edge.
- R6: The bit positions are fixed: 0 transmit write-back, 1 transmit queue empty, 2 link change, 3 receive sequence error, 4 receive descriptor low, 6 receive overrun. Bit 5 and bits 31 to 7 always read 0.
- R7: Bit 2 is set at the first edge at which `link_up` differs from its value at the previous edge, for a change in either direction. The level held during reset is taken as the starting value.
- R8: A transmit write-back with `evt_tx_wb_defer` high and `tx_wb_delay` = D > 0 sets bit 0 exactly D edges after the request edge. With D = 0, or with defer low, the bit is set at the request edge.
- R9: A deferred request that arrives while the timer is running restarts the full delay from the new request. The earlier pending expiry is dropped.
- R10: `irq_out` at each edge takes the OR of (cause bits AND `irq_enable`) as they were before that edge. It therefore falls one cycle after the last enabled cause is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_tx_wb | input | 1 | Transmit descriptor write-back pulse |
| evt_tx_wb_defer | input | 1 | Qualifies `evt_tx_wb` as deferred |
| tx_wb_delay | input | 8 | Deferral length in cycles |
| evt_tx_qempty | input | 1 | Transmit queue empty pulse |
| link_up | input | 1 | Link-up level |
| evt_rx_seqerr | input | 1 | Receive framing sequence error pulse |
| evt_rx_lowdesc | input | 1 | Receive descriptors below threshold pulse |
| evt_rx_overrun | input | 1 | Receive FIFO overrun pulse |
| reg_rd | input | 1 | Read strobe; clears all causes at the edge |
| reg_wr | input | 1 | Write strobe; clears the causes selected by ones |
| reg_wdata | input | 32 | Write data (1 = clear the bit) |
| reg_rdata | output | 32 | Current cause bits |
| irq_enable | input | 32 | Interrupt enable mask |
| irq_out | output | 1 | Registered level interrupt |

## Verification
The assertions assume that `link_up` is already synchronous to `clk` and that the event inputs are sampled once per edge. A pulse held for several cycles therefore counts as several events. They also assume that `tx_wb_delay` is stable whenever a deferred request is taken. The stimulus drives every input half a cycle away from the sampling edge. It changes `tx_wb_delay` only while no request is active. It sweeps every event pattern, every low-order mask and every low-order write pattern. A model that works on whole words predicts each register and interrupt value.

// File: rtl/irq_cause_pkg.sv
// Package: shared widths and cause bit positions for the interrupt cause unit.
// Assumes: cause storage occupies the low CAUSE_W bits of a REG_W register.
package irq_cause_pkg;
    localparam int REG_W   = 32;
    localparam int CAUSE_W = 7;

    localparam int BIT_TXWB   = 0;
    localparam int BIT_TXQE   = 1;
    localparam int BIT_LINK   = 2;
    localparam int BIT_RXSEQ  = 3;
    localparam int BIT_RXLOW  = 4;
    localparam int BIT_RXOVR  = 6;

    // Positions holding real storage; every other position reads zero.
    localparam logic [CAUSE_W-1:0] IMPL_MASK =
        CAUSE_W'((1 << BIT_TXWB) | (1 << BIT_TXQE) | (1 << BIT_LINK) |
                 (1 << BIT_RXSEQ) | (1 << BIT_RXLOW) | (1 << BIT_RXOVR));
endpackage

// File: rtl/link_edge_det.sv
// Module: link_edge_det
// Flags a change of a link-up level in either direction.
// Assumes: link_i is synchronous to clk. Holds the level seen during reset
// as the start value, so no change is reported when reset is released.
module link_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic link_i,
    output logic chg_o
);
    logic link_q;

    // Track the link level from the previous edge.
    always_ff @(posedge clk) begin
        link_q <= link_i;
    end

    assign chg_o = rst_n & (link_i ^ link_q);
endmodule

// File: rtl/txwb_defer_timer.sv
// Module: txwb_defer_timer
// Turns transmit write-back requests into a cause-set pulse, either at once
// or after a reloadable delay of DLY_W bits.
// Assumes: dly_i is stable while a request is taken. A new deferred request
// restarts the count, and a running expiry at that same edge is dropped.
module txwb_defer_timer #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             defer_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             set_o
);
    localparam logic [DLY_W-1:0] CNT_ONE  = DLY_W'(1);
    localparam logic [DLY_W-1:0] CNT_ZERO = '0;

    logic [DLY_W-1:0] cnt_q;
    logic             load;
    logic             now;
    logic             expire;

    // Classify the incoming request as deferred or immediate.
    always_comb begin
        load   = req_i & defer_i & (dly_i != CNT_ZERO);
        now    = req_i & ~(defer_i & (dly_i != CNT_ZERO));
        expire = (cnt_q == CNT_ONE) & ~load;
        set_o  = now | expire;
    end

    // Down-counter: reload on a deferred request, otherwise count to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_ZERO;
        end else if (load) begin
            cnt_q <= dly_i;
        end else if (cnt_q != CNT_ZERO) begin
            cnt_q <= cnt_q - CNT_ONE;
        end
    end

    // R9
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(dly_i)));

    // R8
    countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != CNT_ZERO) |=> (cnt_q == $past(cnt_q) - CNT_ONE));
endmodule

// File: rtl/cause_bit_array.sv
// Module: cause_bit_array
// Sticky cause storage: a set wins over a clear at the same edge.
// Assumes: positions with IMPL bit 0 carry no storage and read zero.
module cause_bit_array #(
    parameter int               WIDTH = 7,
    parameter logic [WIDTH-1:0] IMPL  = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] cause_o
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (IMPL[i]) begin : g_store
            logic bit_q;

            // Hold, clear or set one cause; a new event overrides a clear.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    bit_q <= 1'b0;
                end else begin
                    bit_q <= set_i[i] | (bit_q & ~clr_i[i]);
                end
            end

            assign cause_o[i] = bit_q;

            // R5
            set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                set_i[i] |=> bit_q);

            // R2
            sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (bit_q && !clr_i[i]) |=> bit_q);

            // R4
            clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i[i] && !set_i[i]) |=> !bit_q);
        end else begin : g_tie
            logic unused_pos;
            assign unused_pos = set_i[i] | clr_i[i];
            assign cause_o[i] = 1'b0;
        end
    end
endmodule

// File: rtl/irq_level_reg.sv
// Module: irq_level_reg
// Registers the OR of the enabled causes into one level interrupt.
// Assumes: the mask is applied to the full register width.
module irq_level_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cause_i,
    input  logic [W-1:0] mask_i,
    output logic         irq_o
);
    // Sample the enabled-cause reduction once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= |(cause_i & mask_i);
        end
    end
endmodule

// File: rtl/irq_cause_unit.sv
// Module: irq_cause_unit (top)
// Interrupt cause register with clear-on-read, write-one-to-clear, link
// edge detection, a deferred transmit write-back and a masked level output.
// Assumes: a single read/write strobe pair, and event pulses synchronous to clk.
module irq_cause_unit
    import irq_cause_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_tx_wb,
    input  logic             evt_tx_wb_defer,
    input  logic [DLY_W-1:0] tx_wb_delay,
    input  logic             evt_tx_qempty,
    input  logic             link_up,
    input  logic             evt_rx_seqerr,
    input  logic             evt_rx_lowdesc,
    input  logic             evt_rx_overrun,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [REG_W-1:0] irq_enable,
    output logic             irq_out
);
    localparam int PAD_W = REG_W - CAUSE_W;

    logic               link_chg;
    logic               txwb_set;
    logic [CAUSE_W-1:0] set_vec;
    logic [CAUSE_W-1:0] clr_vec;
    logic [CAUSE_W-1:0] cause_vec;
    logic [REG_W-1:0]   cause_full;
    logic               unused_wdata_hi;

    link_edge_det u_link (
        .clk    (clk),
        .rst_n  (rst_n),
        .link_i (link_up),
        .chg_o  (link_chg)
    );

    txwb_defer_timer #(.DLY_W(DLY_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (evt_tx_wb),
        .defer_i (evt_tx_wb_defer),
        .dly_i   (tx_wb_delay),
        .set_o   (txwb_set)
    );

    // Gather the event sources into their cause positions.
    always_comb begin
        set_vec            = '0;
        set_vec[BIT_TXWB]  = txwb_set;
        set_vec[BIT_TXQE]  = evt_tx_qempty;
        set_vec[BIT_LINK]  = link_chg;
        set_vec[BIT_RXSEQ] = evt_rx_seqerr;
        set_vec[BIT_RXLOW] = evt_rx_lowdesc;
        set_vec[BIT_RXOVR] = evt_rx_overrun;
    end

    // Form the clear request from a read (all bits) or a write of ones.
    always_comb begin
        clr_vec = '0;
        if (reg_rd) begin
            clr_vec = IMPL_MASK;
        end else if (reg_wr) begin
            clr_vec = reg_wdata[CAUSE_W-1:0] & IMPL_MASK;
        end
    end

    assign unused_wdata_hi = ^reg_wdata[REG_W-1:CAUSE_W];

    cause_bit_array #(.WIDTH(CAUSE_W), .IMPL(IMPL_MASK)) u_bits (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_vec),
        .clr_i   (clr_vec),
        .cause_o (cause_vec)
    );

    assign cause_full = {{PAD_W{1'b0}}, cause_vec};
    assign reg_rdata  = cause_full;

    irq_level_reg #(.W(REG_W)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .cause_i (cause_full),
        .mask_i  (irq_enable),
        .irq_o   (irq_out)
    );

    // R7
    link_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_chg |=> reg_rdata[BIT_LINK]);

    // R8
    txwb_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txwb_set |=> reg_rdata[BIT_TXWB]);

    // R10
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(reg_rdata & irq_enable)) |=> irq_out);

    // R10
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(reg_rdata & irq_enable)) |=> !irq_out);

    // R3
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && set_vec == '0) |=> (reg_rdata == '0));
endmodule

// File: tb/irq_cause_unit_bench.sv
module irq_cause_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_tx_wb = 0, evt_tx_wb_defer = 0, evt_tx_qempty = 0;
    logic        link_up = 0, evt_rx_seqerr = 0, evt_rx_lowdesc = 0, evt_rx_overrun = 0;
    logic [7:0]  tx_wb_delay = 0;
    logic        reg_rd = 0, reg_wr = 0;
    logic [31:0] reg_wdata = 0, irq_enable = 0;
    logic [31:0] reg_rdata;
    logic        irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Bench model state
    logic [31:0] m_cause = 0;
    logic        m_irq = 0;
    logic        m_link = 0;
    int          m_cnt = 0;

    always #5 clk = ~clk;

    irq_cause_unit u_irq_cause_unit (
        .clk(clk), .rst_n(rst_n),
        .evt_tx_wb(evt_tx_wb), .evt_tx_wb_defer(evt_tx_wb_defer),
        .tx_wb_delay(tx_wb_delay), .evt_tx_qempty(evt_tx_qempty),
        .link_up(link_up), .evt_rx_seqerr(evt_rx_seqerr),
        .evt_rx_lowdesc(evt_rx_lowdesc), .evt_rx_overrun(evt_rx_overrun),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_enable(irq_enable), .irq_out(irq_out)
    );

    task automatic check(input string tag);
        checks++;
        if (reg_rdata !== m_cause) begin
            fails++;
            $display("FAIL %s rdata=%h expected=%h", tag, reg_rdata, m_cause);
        end
        checks++;
        if (irq_out !== m_irq) begin
            fails++;
            $display("FAIL %s irq_out=%b expected=%b", tag, irq_out, m_irq);
        end
    endtask

    // One cycle: ev uses cause positions (bits 0,1,3,4,6); bit 0 is a write-back request.
    task automatic cyc(input logic [6:0] ev, input logic defer, input logic lnk,
                       input logic rd, input logic wr, input logic [31:0] wd,
                       input logic [31:0] msk, input string tag);
        logic [31:0] setv;
        logic [31:0] clrv;
        logic        dly_nz;
        logic        load;
        @(negedge clk);
        evt_tx_wb = ev[0]; evt_tx_wb_defer = defer; evt_tx_qempty = ev[1];
        evt_rx_seqerr = ev[3]; evt_rx_lowdesc = ev[4]; evt_rx_overrun = ev[6];
        link_up = lnk; reg_rd = rd; reg_wr = wr; reg_wdata = wd; irq_enable = msk;
        dly_nz = (tx_wb_delay != 0);
        load   = ev[0] & defer & dly_nz;
        setv   = 32'(ev) & 32'h5A;
        if (ev[0] && !(defer && dly_nz)) setv[0] = 1'b1;
        if (m_cnt == 1 && !load) setv[0] = 1'b1;
        if (lnk != m_link) setv[2] = 1'b1;
        clrv   = rd ? 32'hFFFF_FFFF : (wr ? wd : 32'h0);
        m_irq  = |(m_cause & msk);
        m_cause = (m_cause & ~clrv) | setv;
        if (load) m_cnt = int'(tx_wb_delay);
        else if (m_cnt != 0) m_cnt = m_cnt - 1;
        m_link = lnk;
        @(posedge clk);
        #1;
        check(tag);
    endtask

    task automatic idle(input string tag);
        cyc(7'h0, 1'b0, m_link, 1'b0, 1'b0, 32'h0, irq_enable, tag);
    endtask

    task automatic rdclr(input string tag);
        cyc(7'h0, 1'b0, m_link, 1'b1, 1'b0, 32'h0, irq_enable, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state, both during and just after reset
        repeat (3) @(posedge clk);
        #1 check("R1 in reset");
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1 check("R1 after reset");

        // R2 / R6: every event pattern, including reserved positions that must stay 0
        for (int p = 0; p < 128; p++) begin
            cyc(7'(p), 1'b0, m_link, 1'b0, 1'b0, 32'h0, 32'h0, "R2 R6 set");
            idle("R2 sticky");
            rdclr("R3 read clear");
        end

        // R10: mask sweep over set, clear and fall
        for (int m = 0; m < 128; m++) begin
            cyc(7'h5B, 1'b0, m_link, 1'b0, 1'b0, 32'h0, 32'(m) | 32'hFFFF_FF80, "R10 set");
            idle("R10 level");
            rdclr("R10 clear");
            idle("R10 fall");
            idle("R10 low");
        end

        // R4: write-one-to-clear sweep, with upper write bits random-ish
        for (int w = 0; w < 128; w++) begin
            cyc(7'h5B, 1'b0, m_link, 1'b0, 1'b0, 32'h0, 32'h0, "R4 fill");
            cyc(7'h0, 1'b0, m_link, 1'b0, 1'b1, 32'(w) | (32'(w) << 20), 32'h0, "R4 write");
            rdclr("R4 tidy");
        end

        // R5: an event at the same edge as a clearing read or write
        cyc(7'h5B, 1'b0, m_link, 1'b0, 1'b0, 32'h0, 32'h0, "R5 fill");
        cyc(7'h0A, 1'b0, m_link, 1'b1, 1'b0, 32'h0, 32'h0, "R5 read vs event");
        cyc(7'h50, 1'b0, m_link, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0, "R5 write vs event");
        rdclr("R5 tidy");

        // R7: link edges both ways, and a change at the same edge as a read
        cyc(7'h0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0, 32'h4, "R7 rise");
        idle("R7 hold");
        rdclr("R7 clear");
        idle("R7 steady");
        cyc(7'h0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0, 32'h4, "R7 fall with read");
        rdclr("R7 clear2");

        // R8: deferred write-back for delays 0..6, with a non-deferred one as well
        for (int d = 0; d < 7; d++) begin
            @(negedge clk); tx_wb_delay = 8'(d);
            cyc(7'h01, 1'b1, m_link, 1'b0, 1'b0, 32'h0, 32'h1, "R8 request");
            for (int k = 0; k < 8; k++) idle("R8 wait");
            rdclr("R8 clear");
            cyc(7'h01, 1'b0, m_link, 1'b0, 1'b0, 32'h0, 32'h1, "R8 immediate");
            rdclr("R8 clear2");
        end

        // R9: a restart while running moves the expiry, and a restart at the expiry edge
        @(negedge clk); tx_wb_delay = 8'd4;
        cyc(7'h01, 1'b1, m_link, 1'b0, 1'b0, 32'h0, 32'h0, "R9 first");
        idle("R9 run"); idle("R9 run");
        cyc(7'h01, 1'b1, m_link, 1'b0, 1'b0, 32'h0, 32'h0, "R9 restart");
        for (int k = 0; k < 6; k++) idle("R9 wait");
        rdclr("R9 clear");
        cyc(7'h01, 1'b1, m_link, 1'b0, 1'b0, 32'h0, 32'h0, "R9 first2");
        idle("R9 run2"); idle("R9 run2"); idle("R9 run2");
        cyc(7'h01, 1'b1, m_link, 1'b0, 1'b0, 32'h0, 32'h0, "R9 restart at expiry");
        for (int k = 0; k < 6; k++) idle("R9 wait2");
        rdclr("R9 clear2");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule